// File: doc/BRIEF.md
# Byte-Packing I2C Data Port

This block sits between a 16-bit register bus and the byte-wide shifter of an I2C master. Software loads a byte count and a direction. On a transmit, each data write carries up to two bytes, which the port gives to the shifter one at a time on request. On a receive, the port collects bytes from the shifter into a 16-bit word that software reads, and it releases a part-filled word when the count runs out.

The port asks for service with a transmit-ready and a receive-ready level. It raises a one-cycle done pulse when the last byte has moved. It records a receive overrun when a byte arrives while the previous word is still unread, and a transmit underflow when the shifter wants a byte that software has not yet supplied. A byte-order control swaps which half of the word carries the earlier byte. A parameter narrows the data register to one byte per access. Start, stop and bus timing belong to other logic.

Top module: `i2c_pack_port`

## Requirements
- R1: A pulse on `cnt_wr` loads `remain` with `cnt_wdata` and the direction `cnt_tx` (1 = transmit). A count of zero loads as one. The load empties both byte paths and clears `rovr`, `xudf` and `rrdy`. After reset, `remain` is 0 and every flag is low.
- R2: On transmit with `swap` low, the byte in bits 7:0 of a data write goes to the shifter first and the byte in bits 15:8 goes second. With `swap` high, this order is reversed. `swap` is sampled at the write.
- R3: A data write made when `remain` is 1 hands only the first byte to the shifter, and the other half of the word is ignored. On receive, a word released with a single byte reads zero in the half that holds no byte.
- R4: `xrdy` is high when in transmit mode, no written byte is still waiting, and `remain` is non-zero. A data write while `xrdy` is low is ignored.
- R5: `rrdy` rises when a received word is complete: two bytes, or fewer when `remain` reaches zero. It stays high until `dat_rd`, which clears it in the same cycle.
- R6: On a receive read with `swap` low, the earlier byte is in bits 7:0 and the later byte is in bits 15:8. With `swap` high, the halves are exchanged.
- R7: A byte that arrives (`sh_rx_vld`) while `rrdy` is high and no read happens in that cycle is dropped, and it sets the sticky `rovr`.
- R8: A shifter request (`sh_tx_req`) in transmit mode with no byte waiting and `remain` non-zero sets the sticky `xudf`, and it moves no byte.
- R9: `remain` falls by one for each byte moved to or from the shifter. `ardy` pulses for one cycle in the cycle after the move that makes `remain` zero.
- R10: With `NARROW` = 1, each access carries one byte in bits 7:0, `swap` has no effect, and bits 15:8 of `dat_rdata` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr | input | 1 | Load count and direction |
| cnt_wdata | input | CNT_W | Byte count to load |
| cnt_tx | input | 1 | Direction at load, 1 = transmit |
| swap | input | 1 | Byte order control |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 16 | Data register write value |
| dat_rd | input | 1 | Data register read strobe |
| dat_rdata | output | 16 | Data register read value |
| sh_tx_req | input | 1 | Shifter takes a byte this cycle |
| sh_tx_byte | output | 8 | Byte offered to the shifter |
| sh_rx_vld | input | 1 | Shifter delivers a byte this cycle |
| sh_rx_byte | input | 8 | Byte from the shifter |
| xrdy | output | 1 | Transmit data wanted |
| rrdy | output | 1 | Received word available |
| ardy | output | 1 | Transfer done pulse |
| rovr | output | 1 | Sticky receive overrun |
| xudf | output | 1 | Sticky transmit underflow |
| remain | output | CNT_W | Bytes still to move |

## Verification
A wrong count or a wrong held-byte tally shows up at the ports within one clock. It appears as a `remain` that does not step, a transmit-ready that does not match the bytes held, or a done pulse in the wrong cycle. A byte-order or fill error in the receive word shows in `dat_rdata` as soon as `rrdy` rises. A misplaced transmit byte shows on `sh_tx_byte` before the shifter takes it. Because the reference model is compared on every clock, a fault is reported in the cycle it first reaches a port, not at the end of the transfer.

// File: rtl/i2c_pack_port.sv
module i2c_pack_port #(
  parameter int CNT_W  = 16,
  parameter bit NARROW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             cnt_tx,
  input  logic             swap,
  input  logic             dat_wr,
  input  logic [15:0]      dat_wdata,
  input  logic             dat_rd,
  output logic [15:0]      dat_rdata,
  input  logic             sh_tx_req,
  output logic [7:0]       sh_tx_byte,
  input  logic             sh_rx_vld,
  input  logic [7:0]       sh_rx_byte,
  output logic             xrdy,
  output logic             rrdy,
  output logic             ardy,
  output logic             rovr,
  output logic             xudf,
  output logic [CNT_W-1:0] remain
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [1:0] PER_WORD = NARROW ? 2'd1 : 2'd2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic       tx_mode;
  logic [1:0] txn;
  logic [7:0] tb0, tb1;
  logic [1:0] rxn;
  logic [7:0] rb0, rb1;
  logic       rx_full;

  wire rem_nz     = remain != '0;
  wire tx_pop     = tx_mode && sh_tx_req && txn != 2'd0;
  wire tx_miss    = tx_mode && sh_tx_req && txn == 2'd0 && rem_nz;
  wire rd_take    = !tx_mode && dat_rd && rx_full;
  wire rx_blocked = rx_full && !rd_take;
  wire rx_push    = !tx_mode && sh_rx_vld && !rx_blocked && rem_nz;
  wire rx_ovr     = !tx_mode && sh_rx_vld && rx_blocked;
  wire wr_take    = dat_wr && xrdy;
  wire dec        = tx_pop || rx_push;
  wire two        = !NARROW && (remain > ONE);
  wire swap_eff   = swap && !NARROW;
  wire [1:0] rxn_base = rd_take ? 2'd0 : rxn;
  wire [1:0] rxn_inc  = rxn_base + 2'd1;

  assign xrdy       = tx_mode && txn == 2'd0 && rem_nz;
  assign rrdy       = rx_full;
  assign sh_tx_byte = tb0;
  assign dat_rdata  = swap_eff ? {rb0, rb1} : {rb1, rb0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain  <= '0;
      tx_mode <= 1'b0;
      txn     <= 2'd0;
      tb0     <= 8'h00;
      tb1     <= 8'h00;
      rxn     <= 2'd0;
      rb0     <= 8'h00;
      rb1     <= 8'h00;
      rx_full <= 1'b0;
      ardy    <= 1'b0;
      rovr    <= 1'b0;
      xudf    <= 1'b0;
    end else if (cnt_wr) begin
      remain  <= (cnt_wdata == '0) ? ONE : cnt_wdata;
      tx_mode <= cnt_tx;
      txn     <= 2'd0;
      rxn     <= 2'd0;
      rb0     <= 8'h00;
      rb1     <= 8'h00;
      rx_full <= 1'b0;
      ardy    <= 1'b0;
      rovr    <= 1'b0;
      xudf    <= 1'b0;
    end else begin
      ardy <= dec && remain == ONE;
      if (dec)     remain <= remain - ONE;
      if (tx_miss) xudf <= 1'b1;
      if (rx_ovr)  rovr <= 1'b1;

      if (tx_pop) begin
        tb0 <= tb1;
        txn <= txn - 2'd1;
      end else if (wr_take) begin
        tb0 <= swap_eff ? dat_wdata[15:8] : dat_wdata[7:0];
        tb1 <= swap_eff ? dat_wdata[7:0]  : dat_wdata[15:8];
        txn <= two ? 2'd2 : 2'd1;
      end

      if (rd_take) rx_full <= 1'b0;
      if (rx_push) begin
        if (rxn_base == 2'd0) begin
          rb0 <= sh_rx_byte;
          rb1 <= 8'h00;
        end else begin
          rb1 <= sh_rx_byte;
        end
        rxn <= rxn_inc;
        if (rxn_inc == PER_WORD || remain == ONE) rx_full <= 1'b1;
      end else if (rd_take) begin
        rxn <= 2'd0;
      end
    end
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> remain != '0); // R1
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && dat_wr && !xrdy && !sh_tx_req) |=> $stable(sh_tx_byte)); // R4
  AST_RRDY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rrdy && !dat_rd && !cnt_wr) |=> rrdy); // R5
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !tx_mode && sh_rx_vld && rrdy && !dat_rd) |=> rovr); // R7
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && tx_mode && sh_tx_req && txn == 2'd0 && remain != '0) |=> xudf); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && tx_mode && sh_tx_req && txn != 2'd0) |=> remain == $past(remain) - ONE); // R9
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ardy |-> remain == '0); // R9
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    NARROW |-> dat_rdata[15:8] == 8'h00); // R10
endmodule

// File: tb/tb_i2c_pack_port.sv
module tb_i2c_pack_port;
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cnt_wr = 0, cnt_tx = 0, swap = 0, dat_wr = 0, dat_rd = 0;
  logic          sh_tx_req = 0, sh_rx_vld = 0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [15:0]   dat_wdata = '0;
  logic [7:0]    sh_rx_byte = '0;
  logic [15:0]   dat_rdata;
  logic [7:0]    sh_tx_byte;
  logic          xrdy, rrdy, ardy, rovr, xudf;
  logic [CW-1:0] remain;

  i2c_pack_port #(.CNT_W(CW), .NARROW(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_tx(cnt_tx),
    .swap(swap), .dat_wr(dat_wr), .dat_wdata(dat_wdata), .dat_rd(dat_rd),
    .dat_rdata(dat_rdata), .sh_tx_req(sh_tx_req), .sh_tx_byte(sh_tx_byte),
    .sh_rx_vld(sh_rx_vld), .sh_rx_byte(sh_rx_byte), .xrdy(xrdy), .rrdy(rrdy),
    .ardy(ardy), .rovr(rovr), .xudf(xudf), .remain(remain));

  logic          n_cnt_wr = 0, n_swap = 0, n_dat_wr = 0, n_req = 0;
  logic [CW-1:0] n_cnt = '0;
  logic [15:0]   n_wdata = '0;
  logic [15:0]   n_rdata;
  logic [7:0]    n_byte;
  logic          n_xrdy, n_rrdy, n_ardy, n_rovr, n_xudf;
  logic [CW-1:0] n_remain;

  i2c_pack_port #(.CNT_W(CW), .NARROW(1'b1)) dut8 (
    .clk(clk), .rst_n(rst_n), .cnt_wr(n_cnt_wr), .cnt_wdata(n_cnt), .cnt_tx(1'b1),
    .swap(n_swap), .dat_wr(n_dat_wr), .dat_wdata(n_wdata), .dat_rd(1'b0),
    .dat_rdata(n_rdata), .sh_tx_req(n_req), .sh_tx_byte(n_byte),
    .sh_rx_vld(1'b0), .sh_rx_byte(8'h00), .xrdy(n_xrdy), .rrdy(n_rrdy),
    .ardy(n_ardy), .rovr(n_rovr), .xudf(n_xudf), .remain(n_remain));

  int vec = 0, miss = 0;
  bit done = 0;

  int  m_rem;
  bit  m_tx, m_rxfull, m_rovr, m_xudf, m_ardy;
  byte unsigned m_txq[$];
  byte unsigned m_rxq[$];

  always @(posedge clk) begin
    int rp;
    bit xr, full_eff;
    byte unsigned b1, b2;
    if (!rst_n) begin
      m_rem = 0; m_tx = 0; m_rxfull = 0; m_rovr = 0; m_xudf = 0; m_ardy = 0;
      m_txq.delete(); m_rxq.delete();
    end else if (cnt_wr) begin
      m_rem = (cnt_wdata == 0) ? 1 : int'(cnt_wdata);
      m_tx = cnt_tx; m_rxfull = 0; m_rovr = 0; m_xudf = 0; m_ardy = 0;
      m_txq.delete(); m_rxq.delete();
    end else begin
      rp = m_rem;
      xr = m_tx && m_txq.size() == 0 && rp != 0;
      m_ardy = 0;
      if (m_tx) begin
        if (sh_tx_req) begin
          if (m_txq.size() > 0) begin
            void'(m_txq.pop_front());
            m_rem--;
            if (m_rem == 0) m_ardy = 1;
          end else if (rp != 0) m_xudf = 1;
        end
        if (dat_wr && xr) begin
          b1 = swap ? dat_wdata[15:8] : dat_wdata[7:0];
          b2 = swap ? dat_wdata[7:0]  : dat_wdata[15:8];
          m_txq.push_back(b1);
          if (rp >= 2) m_txq.push_back(b2);
        end
      end else begin
        full_eff = m_rxfull;
        if (dat_rd && m_rxfull) begin
          m_rxfull = 0; m_rxq.delete(); full_eff = 0;
        end
        if (sh_rx_vld) begin
          if (full_eff) m_rovr = 1;
          else if (m_rem > 0) begin
            m_rxq.push_back(sh_rx_byte);
            m_rem--;
            if (m_rem == 0) m_ardy = 1;
            if (m_rxq.size() == 2 || m_rem == 0) m_rxfull = 1;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit e_xrdy;
    logic [15:0] e_rd;
    e_xrdy = m_tx && m_txq.size() == 0 && m_rem != 0;
    chk(remain == CW'(m_rem), "R9 remain", remain, m_rem);
    chk(ardy == m_ardy, "R9 ardy", ardy, m_ardy);
    chk(xrdy == e_xrdy, "R4 xrdy", xrdy, e_xrdy);
    chk(rrdy == m_rxfull, "R5 rrdy", rrdy, m_rxfull);
    chk(rovr == m_rovr, "R7 rovr", rovr, m_rovr);
    chk(xudf == m_xudf, "R8 xudf", xudf, m_xudf);
    if (m_txq.size() > 0)
      chk(sh_tx_byte == m_txq[0], "R2 tx byte", sh_tx_byte, m_txq[0]);
    if (m_rxfull) begin
      e_rd = {(m_rxq.size() > 1) ? m_rxq[1] : 8'h00, m_rxq[0]};
      if (swap) e_rd = {e_rd[7:0], e_rd[15:8]};
      chk(dat_rdata == e_rd, "R6 rx word", dat_rdata, e_rd);
    end
  endtask

  task automatic clr();
    cnt_wr = 0; dat_wr = 0; dat_rd = 0; sh_tx_req = 0; sh_rx_vld = 0;
    n_cnt_wr = 0; n_dat_wr = 0; n_req = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    clr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare();
    chk(remain == 0 && !xrdy && !rrdy && !rovr && !xudf, "R1 reset state", remain, 0);
    rst_n = 1;

    cnt_wr = 1; cnt_wdata = '0; cnt_tx = 1;
    n_cnt_wr = 1; n_cnt = CW'(2);
    tick();
    chk(remain == 1, "R1 zero loads one", remain, 1);
    chk(n_remain == 2, "R10 narrow load", n_remain, 2);

    dat_wr = 1; dat_wdata = 16'hBEEF; swap = 0;
    n_dat_wr = 1; n_wdata = 16'hAB12; n_swap = 1;
    tick();
    chk(sh_tx_byte == 8'hEF, "R3 single byte first", sh_tx_byte, 8'hEF);
    chk(n_byte == 8'h12 && !n_xrdy, "R10 narrow one byte", n_byte, 8'h12);
    sh_tx_req = 1; n_req = 1;
    tick();
    chk(remain == 0 && ardy, "R9 done pulse", {remain, ardy}, 1);
    chk(!xrdy, "R3 upper half ignored", xrdy, 0);
    chk(n_remain == 1 && n_xrdy, "R10 narrow ready again", n_remain, 1);
    n_dat_wr = 1; n_wdata = 16'h3456;
    tick();
    chk(!ardy, "R9 pulse one cycle", ardy, 0);
    chk(n_byte == 8'h56, "R10 swap ignored", n_byte, 8'h56);
    chk(n_rdata[15:8] == 8'h00, "R10 upper read zero", n_rdata, 0);

    cnt_wr = 1; cnt_wdata = CW'(3); cnt_tx = 0; swap = 0;
    tick();
    sh_rx_vld = 1; sh_rx_byte = 8'h11; tick();
    sh_rx_vld = 1; sh_rx_byte = 8'h22; tick();
    chk(rrdy && dat_rdata == 16'h2211, "R6 rx order", dat_rdata, 16'h2211);
    sh_rx_vld = 1; sh_rx_byte = 8'h33; tick();
    chk(rovr && remain == 1, "R7 overrun drop", {rovr, remain}, 17'h10001);
    dat_rd = 1; tick();
    sh_rx_vld = 1; sh_rx_byte = 8'h44; tick();
    chk(rrdy && dat_rdata == 16'h0044, "R3 rx upper zero", dat_rdata, 16'h0044);
    swap = 1; @(negedge clk) ;
    chk(dat_rdata == 16'h4400, "R6 rx swap", dat_rdata, 16'h4400);
    compare(); clr();
    swap = 0;

    cnt_wr = 1; cnt_wdata = CW'(2); cnt_tx = 1; tick();
    sh_tx_req = 1; tick();
    chk(xudf && remain == 2, "R8 underflow", {xudf, remain}, 17'h10002);
    dat_wr = 1; dat_wdata = 16'hC3A5; swap = 1; tick();
    chk(sh_tx_byte == 8'hC3, "R2 tx swap first", sh_tx_byte, 8'hC3);
    dat_wr = 1; dat_wdata = 16'h0000; tick();
    chk(sh_tx_byte == 8'hC3, "R4 busy write ignored", sh_tx_byte, 8'hC3);
    sh_tx_req = 1; tick();
    chk(sh_tx_byte == 8'hA5, "R2 tx swap second", sh_tx_byte, 8'hA5);
    sh_tx_req = 1; tick();

    for (int i = 0; i < 5000; i++) begin
      if (remain == 0 && !rrdy && ($urandom % 4 == 0)) begin
        cnt_wr = 1; cnt_wdata = CW'($urandom % 8);
        cnt_tx = $urandom % 2; swap = $urandom % 2;
      end else begin
        sh_tx_req  = ($urandom % 4 == 0);
        dat_wr     = (xrdy && ($urandom % 2 == 0)) || ($urandom % 16 == 0);
        dat_wdata  = 16'($urandom);
        sh_rx_vld  = ($urandom % 3 == 0);
        sh_rx_byte = 8'($urandom);
        dat_rd     = (rrdy && ($urandom % 3 != 0)) || ($urandom % 20 == 0);
      end
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      miss++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
    end
  end
endmodule